// File: doc/BRIEF.md
# Registered 8-bit ALU with Status Flag Merge

This block is the arithmetic and logic stage of a small RISC core. Each cycle it takes an operation code, two operands and the current six-bit status word. One clock later it presents the result, the new status word and a mask that shows which flags the operation wrote. Flags the operation does not own are copied from the incoming status word, so the core can store the status word whole without any merge logic of its own.

The operation set covers these groups:
- add and subtract, each with or without carry
- bitwise AND, OR and XOR
- one's complement and negate
- increment and decrement
- five single-bit shifts and rotates
- nibble exchange

The carry input of the arithmetic and rotate operations is taken from the C bit of the incoming status word. Subtract-with-carry also reads the incoming Z bit, so that multi-byte compares can be chained.

Top module: `alu8_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_o`, `flags_o` and `fmask_o` become all zeros.
- R2: Op 0 (add) and op 1 (add plus carry-in) return the low 8 bits of the sum. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow. All six flags are written.
- R3: Op 2 (subtract) returns a minus b. C is set when a borrow is needed, H is set on a borrow from bit 4 into bit 3, and V is set on signed overflow. All six flags are written.
- R4: Op 3 (subtract with carry) returns a minus b minus carry-in, with C, H and V as in R3. Z is set only when the result is zero and the incoming Z was 1. A nonzero result clears Z.
- R5: Ops 4, 5 and 6 (AND, OR, XOR) write only Z, N, V and S. V is 0, and C and H keep their incoming values.
- R6: Op 7 (one's complement) returns 0xFF minus a. It sets C to 1 and V to 0, writes Z, N and S, and keeps H.
- R7: Op 8 (negate) returns 0x00 minus a and writes all six flags. C is set when a is nonzero, V is set only when a is 0x80, and H is set when the low nibble of a is nonzero.
- R8: Op 9 (increment) and op 10 (decrement) write only Z, N, V and S. V is set for an increment of 0x7F and for a decrement of 0x80, and C and H keep their incoming values.
- R9: Ops 11 to 15 are shift left, shift right, rotate left through C, rotate right through C and arithmetic shift right. C takes the bit shifted out and V = N xor new C. They write C, Z, N, V and S and keep H.
- R10: Op 16 exchanges bits 7..4 with bits 3..0. It writes no flag, so `fmask_o` is 0 and `flags_o` equals the incoming flags.
- R11: The status bits are C=0, Z=1, N=2, V=3, S=4, H=5. Each output flag whose mask bit is 0 equals the incoming flag of the previous cycle. Every output appears exactly one cycle after its inputs. Op codes 17 to 31 give result 0 and mask 0.
- R12: Whenever S is written, it equals N xor V of the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (the only operand for single-operand ops) |
| b_i | input | 8 | Second operand |
| flags_i | input | 6 | Incoming status word {H,S,V,N,Z,C} |
| res_o | output | 8 | Registered result |
| flags_o | output | 6 | Registered merged status word |
| fmask_o | output | 6 | Registered mask of the flags written by the operation |

## Verification
The block has one register stage and no other state. A wrong internal choice therefore shows at the ports in the cycle right after the inputs are applied, either as a wrong result or as a flag that was written or kept wrongly. The hard cases are those where a wrong choice still gives a plausible value:
- the Z chaining of subtract-with-carry, which appears only when the result is zero and the incoming Z differs;
- the borrow sense of H and C;
- the V rule of the shifts;
- the kept C and H around logic and increment ops, which a fault exposes only when the incoming flag was 1.

The directed vectors target each of these. The randomised stream varies the incoming flags so that every kept bit is observed in both states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_COM  = 5'd7,
    OP_NEG  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // mask layout {H,S,V,N,Z,C}
  function automatic logic [FLAG_W-1:0] flag_mask(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:  flag_mask = 6'b111111;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:   flag_mask = 6'b011110;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                                  flag_mask = 6'b011111;
      default:                                 flag_mask = 6'b000000;
    endcase
  endfunction

  function automatic logic is_arith(input logic [4:0] op);
    is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_NEG) || (op == OP_INC) ||
               (op == OP_DEC);
  endfunction

  function automatic logic is_shift(input logic [4:0] op);
    is_shift = (op >= OP_LSL) && (op <= OP_ASR);
  endfunction

  function automatic logic is_bitwise(input logic [4:0] op);
    is_bitwise = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                 (op == OP_COM) || (op == OP_SWAP);
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         h,
  output logic         v,
  output logic         c
);
  localparam int NB = W / 2;

  logic [W-1:0] x, y;
  logic         k, sub;
  logic [W:0]   wide;
  logic [NB:0]  nib;

  // operand steering: every arithmetic op is x +/- y +/- k
  always_comb begin
    x   = a;
    y   = b;
    k   = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADC: k = cin;
      OP_SUB: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; k = cin; end
      OP_NEG: begin x = '0; y = a; sub = 1'b1; end
      OP_INC: y = W'(1);
      OP_DEC: begin y = W'(1); sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (sub) begin
      wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, k};
      nib  = {1'b0, x[NB-1:0]} - {1'b0, y[NB-1:0]} - {{NB{1'b0}}, k};
    end else begin
      wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, k};
      nib  = {1'b0, x[NB-1:0]} + {1'b0, y[NB-1:0]} + {{NB{1'b0}}, k};
    end
  end

  assign res = wide[W-1:0];
  assign c   = wide[W];
  assign h   = nib[NB];
  assign v   = sub ? ((x[W-1] != y[W-1]) && (res[W-1] != x[W-1]))
                   : ((x[W-1] == y[W-1]) && (res[W-1] != x[W-1]));
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int NB = W / 2;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_SWAP: res = {a[NB-1:0], a[W-1:NB]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c
);
  always_comb begin
    res = a;
    c   = 1'b0;
    case (op)
      OP_LSL: begin res = {a[W-2:0], 1'b0};     c = a[W-1]; end
      OP_LSR: begin res = {1'b0, a[W-1:1]};     c = a[0];   end
      OP_ROL: begin res = {a[W-2:0], cin};      c = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};      c = a[0];   end
      OP_ASR: begin res = {a[W-1], a[W-1:1]};   c = a[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] fmask_o
);
  logic [W-1:0]      as_res, bw_res, sh_res, res_d;
  logic              as_h, as_v, as_c, sh_c;
  logic              n_d, z_d, v_d, c_d, s_d;
  logic [FLAG_W-1:0] new_f, mask_d, merged_d;
  logic              live_q;

  alu8_addsub #(.W(W)) u_addsub (
    .op(op_i), .a(a_i), .b(b_i), .cin(flags_i[FC]),
    .res(as_res), .h(as_h), .v(as_v), .c(as_c)
  );

  alu8_bitwise #(.W(W)) u_bitwise (
    .op(op_i), .a(a_i), .b(b_i), .res(bw_res)
  );

  alu8_shifter #(.W(W)) u_shifter (
    .op(op_i), .a(a_i), .cin(flags_i[FC]), .res(sh_res), .c(sh_c)
  );

  always_comb begin
    if (is_arith(op_i))        res_d = as_res;
    else if (is_shift(op_i))   res_d = sh_res;
    else if (is_bitwise(op_i)) res_d = bw_res;
    else                       res_d = '0;
  end

  always_comb begin
    n_d = res_d[W-1];
    z_d = (res_d == '0) && ((op_i != OP_SBC) || flags_i[FZ]);
    if (is_arith(op_i))      begin v_d = as_v;       c_d = as_c; end
    else if (is_shift(op_i)) begin v_d = n_d ^ sh_c; c_d = sh_c; end
    else                     begin v_d = 1'b0;       c_d = 1'b1; end
    s_d      = n_d ^ v_d;
    new_f    = {as_h, s_d, v_d, n_d, z_d, c_d};
    mask_d   = flag_mask(op_i);
    merged_d = (new_f & mask_d) | (flags_i & ~mask_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      fmask_o <= '0;
      live_q  <= 1'b0;
    end else begin
      res_o   <= res_d;
      flags_o <= merged_d;
      fmask_o <= mask_d;
      live_q  <= 1'b1;
    end
  end

  // R11: unwritten flags carry last cycle's incoming status
  p_kept_flags_r11: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((flags_o & ~fmask_o) == ($past(flags_i) & ~fmask_o)));

  // R12: sign flag consistent with N and V when written
  p_s_matches_r12: assert property (@(posedge clk) disable iff (rst)
    (live_q && fmask_o[FS]) |-> (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])));

  // R10: nibble exchange writes no flag
  p_swap_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_SWAP)) |-> (fmask_o == '0));

  // R6: complement forces carry set and overflow clear
  p_com_forces_r6: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_COM)) |-> (flags_o[FC] && !flags_o[FV]));

  // R4: a nonzero subtract-with-carry result always clears Z
  p_sbc_zchain_r4: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_SBC) && (res_o != '0)) |-> !flags_o[FZ]);

  // R7: negate carry tracks a nonzero result
  p_neg_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_NEG)) |-> (flags_o[FC] == (res_o != '0)));
endmodule

// File: tb/alu8_flag_unit_tb.sv
module alu8_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [5:0] flags_i = '0;
  logic [7:0] res_o;
  logic [5:0] flags_o, fmask_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int op; int a; int b; int f; int r; int nf; int m; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  alu8_flag_unit dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o)
  );

  function automatic int sg(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9, 10: return "R8";
      11, 12, 13, 14, 15: return "R9";
      16: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int op, a, b, f, output int r, nf, m);
    int ci, zi, k, t, sv, h, v, c, n, z, s, newf;
    ci = f & 1; zi = (f >> 1) & 1;
    h = 0; v = 0; c = 0; r = 0; m = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? ci : 0; t = a + b + k; r = t & 255; c = (t > 255);
        h = (((a & 15) + (b & 15) + k) > 15);
        sv = sg(a) + sg(b) + k; v = (sv > 127 || sv < -128); m = 63;
      end
      2, 3: begin
        k = (op == 3) ? ci : 0; t = a - b - k; r = t & 255; c = (t < 0);
        h = (((a & 15) - (b & 15) - k) < 0);
        sv = sg(a) - sg(b) - k; v = (sv > 127 || sv < -128); m = 63;
      end
      4: begin r = a & b; m = 30; end
      5: begin r = a | b; m = 30; end
      6: begin r = a ^ b; m = 30; end
      7: begin r = 255 - a; c = 1; m = 31; end
      8: begin r = (256 - a) & 255; c = (a != 0); h = ((a & 15) != 0); v = (a == 128); m = 63; end
      9: begin r = (a + 1) & 255; v = (a == 127); m = 30; end
      10: begin r = (a + 255) & 255; v = (a == 128); m = 30; end
      11: begin r = (a << 1) & 255; c = a >> 7; m = 31; end
      12: begin r = a >> 1; c = a & 1; m = 31; end
      13: begin r = ((a << 1) | ci) & 255; c = a >> 7; m = 31; end
      14: begin r = (a >> 1) | (ci << 7); c = a & 1; m = 31; end
      15: begin r = (a >> 1) | (a & 128); c = a & 1; m = 31; end
      16: begin r = ((a & 15) << 4) | (a >> 4); m = 0; end
      default: begin r = 0; m = 0; end
    endcase
    n = r >> 7;
    if (op >= 11 && op <= 15) v = n ^ c;
    z = (r == 0);
    if (op == 3) z = z && zi;
    s = n ^ v;
    newf = (h << 5) | (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
    nf = (newf & m) | (f & ~m & 63);
  endtask

  task automatic apply(input int op, a, b, f);
    exp_t e;
    @(negedge clk);
    op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); flags_i = 6'(f);
    e.op = op; e.a = a; e.b = b; e.f = f;
    model(op, a, b, f, e.r, e.nf, e.m);
    q.push_back(e);
    @(posedge clk); #1;
    e = q.pop_front();
    checks++;
    if (int'(res_o) != e.r || int'(flags_o) != e.nf || int'(fmask_o) != e.m) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: res=%02h flags=%02h mask=%02h expected res=%02h flags=%02h mask=%02h",
               req_of(op), op, a, b, f, res_o, flags_o, fmask_o, e.r, e.nf, e.m);
    end
    // R11: unwritten flags copy the incoming word
    checks++;
    if ((int'(flags_o) & ~int'(fmask_o) & 63) != (f & ~int'(fmask_o) & 63)) begin
      failures++;
      $display("FAIL R11 kept flags %02h expected %02h", int'(flags_o) & ~int'(fmask_o) & 63,
               f & ~int'(fmask_o) & 63);
    end
    // R12: S = N xor V whenever written
    if (fmask_o[4]) begin
      checks++;
      if (flags_o[4] != (flags_o[2] ^ flags_o[3])) begin
        failures++;
        $display("FAIL R12 S=%0d expected %0d", flags_o[4], flags_o[2] ^ flags_o[3]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with live inputs
    op_i = 5'd0; a_i = 8'hFF; b_i = 8'hFF; flags_i = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (res_o != 0 || flags_o != 0 || fmask_o != 0) begin
      failures++;
      $display("FAIL R1 res=%02h flags=%02h mask=%02h expected 00 00 00", res_o, flags_o, fmask_o);
    end
    @(negedge clk); rst = 1'b0;

    apply(0, 8'h7F, 8'h01, 0);       // R2 signed overflow, half carry
    apply(0, 8'hFF, 8'h01, 0);       // R2 carry, zero
    apply(1, 8'h0F, 8'h00, 1);       // R2 carry-in into H
    apply(2, 8'h00, 8'h01, 0);       // R3 borrow
    apply(2, 8'h80, 8'h01, 0);       // R3 overflow
    apply(2, 8'h10, 8'h01, 0);       // R3 nibble borrow
    apply(3, 8'h05, 8'h04, 6'h03);   // R4 zero result, Z in 1 -> Z 1
    apply(3, 8'h05, 8'h04, 6'h01);   // R4 zero result, Z in 0 -> Z 0
    apply(3, 8'h05, 8'h03, 6'h03);   // R4 nonzero clears Z
    apply(4, 8'hF0, 8'h0F, 6'h21);   // R5 C and H kept set
    apply(6, 8'h80, 8'h00, 6'h08);   // R5 V forced low
    apply(7, 8'h00, 8'h00, 6'h20);   // R6 H kept
    apply(8, 8'h80, 8'h00, 0);       // R7 overflow case
    apply(8, 8'h00, 8'h00, 6'h3F);   // R7 zero operand
    apply(8, 8'h10, 8'h00, 0);       // R7 H clear
    apply(9, 8'h7F, 8'h00, 6'h21);   // R8 overflow, C/H kept
    apply(9, 8'hFF, 8'h00, 6'h01);   // R8 wrap keeps C
    apply(10, 8'h80, 8'h00, 0);      // R8 overflow
    apply(11, 8'h80, 8'h00, 0);      // R9 shift left out
    apply(12, 8'h01, 8'h00, 6'h20);  // R9 shift right, H kept
    apply(13, 8'h40, 8'h00, 6'h01);  // R9 rotate left with C
    apply(14, 8'h02, 8'h00, 6'h01);  // R9 rotate right with C
    apply(15, 8'h81, 8'h00, 0);      // R9 arithmetic shift
    apply(16, 8'h3C, 8'h00, 6'h3F);  // R10 swap, flags untouched
    apply(20, 8'h55, 8'hAA, 6'h15);  // R11 unused code
    apply(31, 8'hFF, 8'hFF, 6'h2A);  // R11 unused code

    for (int i = 0; i < 6000; i++) begin
      int op;
      op = (i % 8 == 7) ? int'($urandom_range(31, 0)) : int'($urandom_range(16, 0));
      apply(op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(63, 0)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule